// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between a set of interrupt-flag producers and a processor core. Twenty-one request lines, each gated by its own enable bit, are folded onto ten vectors. Every vector carries a one-bit level choice. Vectors 0 and 1 can run at the top level or the bottom level. Vectors 2 to 9 can run at the middle level or the bottom level. The arbiter picks one winning vector, raises a request to the core while that winner outranks everything already being serviced, and latches the winner's entry address when the core acknowledges.

A three-bit in-service record remembers which levels are open. An acknowledge opens the granted level. A return strobe closes the highest open level. Nesting is therefore limited to a strictly rising chain of levels. Flag generation inside the sources and the core's context saving are handled elsewhere.

Top module: `intr_arb_top`

## Requirements
- R1: After reset, irqReq is 0, irqVec is 0x0000 and no level is in service.
- R2: A vector is pending when any of its sources has both srcReq and srcEn set. Sources are grouped by index onto vectors as follows: vector 0 = source 0; vector 1 = source 1; vector 2 = sources 2..4; vector 3 = sources 5..6; vector 4 = source 7; vector 5 = sources 8..9; vector 6 = sources 10..11; vector 7 = sources 12..14; vector 8 = sources 15..17; vector 9 = sources 18..20. A source whose enable bit is 0 has no effect.
- R3: Level encoding is L=1, H=2, X=3. When vecLvlHi[v]=1, vector v runs at X if v<2 and at H otherwise. When vecLvlHi[v]=0, vector v runs at L.
- R4: Among pending vectors, the one with the highest level wins. Among vectors of equal level, the one with the lowest index wins.
- R5: irqReq is combinational and equals 1 exactly when the winner's level is strictly above the highest level in service (0 when nothing is in service).
- R6: When cpuAck=1, irqReq=1 and cpuRet=0 at a clock edge, irqVec shows 0x0003 + 8*winner after that edge and the winner's level is put in service. At every other edge irqVec keeps its value.
- R7: An acknowledge while irqReq=0 is ignored. An acknowledge in the same cycle as cpuRet is also ignored.
- R8: cpuRet removes only the highest level in service. A return with nothing in service changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcReq | input | 21 | Per-source request flags |
| srcEn | input | 21 | Per-source enable mask |
| vecLvlHi | input | 10 | Per-vector level choice (1 = upper level of its slot) |
| cpuAck | input | 1 | Core accepts the offered interrupt |
| cpuRet | input | 1 | Core finished the current handler |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | 16 | Entry address latched at the last grant |

## Verification
irqReq responds in the same cycle as any change to the requests, enables, level choices or in-service state. The bench therefore samples it one time step after driving new inputs at the falling edge. The vector address appears one rising edge after a grant. The acknowledge driver pushes the address it expects into a queue, and a monitor pops and compares that entry just after the next rising edge. Returns and ignored acknowledges take effect at the next rising edge, and the bench observes them through irqReq at the following falling edge, compared against a level model kept in the bench.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int NUM_SRC   = 21;
  localparam int NUM_VEC   = 10;
  localparam int ADDR_W    = 16;
  localparam int VEC_BASE  = 3;
  localparam int VEC_STEP  = 8;
  localparam int TOP_SLOTS = 2;   // vectors below this index may take the top level

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_L    = 2'd1;
  localparam lvl_t LVL_H    = 2'd2;
  localparam lvl_t LVL_X    = 2'd3;

  typedef struct packed {
    logic grant;
    logic retire;
  } ctl_strobe_t;

  // number of sources folded onto each vector
  function automatic int groupSize(input int v);
    case (v)
      2, 7, 8, 9: return 3;
      3, 5, 6:    return 2;
      default:    return 1;
    endcase
  endfunction

  // vector that owns source s
  function automatic int srcGroup(input int s);
    int acc = 0;
    for (int v = 0; v < NUM_VEC; v++) begin
      acc += groupSize(v);
      if (s < acc) return v;
    end
    return NUM_VEC - 1;
  endfunction
endpackage

// File: rtl/intr_arb_dp.sv
module intr_arb_dp
  import intr_arb_pkg::*;
#(
  parameter int NSRC  = NUM_SRC,
  parameter int NVEC  = NUM_VEC,
  parameter int AW    = ADDR_W,
  parameter int BASE  = VEC_BASE,
  parameter int STEP  = VEC_STEP,
  parameter int NTOP  = TOP_SLOTS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcReq,
  input  logic [NSRC-1:0] srcEn,
  input  logic [NVEC-1:0] vecLvlHi,
  input  ctl_strobe_t     strobe,
  output lvl_t            winLvl,
  output logic [AW-1:0]   irqVec
);
  localparam int IDX_W = $clog2(NVEC);

  logic [NSRC-1:0] maskedReq;
  logic [NVEC-1:0] vecPend;
  lvl_t            vecLvl [NVEC];
  logic [IDX_W-1:0] winIdx;

  assign maskedReq = srcReq & srcEn;

  always_comb begin
    vecPend = '0;
    for (int s = 0; s < NSRC; s++)
      vecPend[srcGroup(s)] = vecPend[srcGroup(s)] | maskedReq[s];
  end

  for (genvar v = 0; v < NVEC; v++) begin : g_lvl
    localparam lvl_t UPPER = (v < NTOP) ? LVL_X : LVL_H;
    assign vecLvl[v] = !vecPend[v] ? LVL_NONE : (vecLvlHi[v] ? UPPER : LVL_L);
  end

  // scan downward with >= so the lowest index wins a tie
  always_comb begin
    winLvl = LVL_NONE;
    winIdx = '0;
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (vecLvl[v] != LVL_NONE && vecLvl[v] >= winLvl) begin
        winLvl = vecLvl[v];
        winIdx = IDX_W'(v);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqVec <= '0;
    else if (strobe.grant)
      irqVec <= AW'(BASE) + AW'(STEP) * AW'(winIdx);
  end
endmodule

// File: rtl/intr_arb_ctl.sv
module intr_arb_ctl
  import intr_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lvl_t        winLvl,
  input  logic        cpuAck,
  input  logic        cpuRet,
  output logic        irqReq,
  output ctl_strobe_t strobe,
  output logic [2:0]  inSvc
);
  lvl_t curLvl;

  always_comb begin
    if (inSvc[2])      curLvl = LVL_X;
    else if (inSvc[1]) curLvl = LVL_H;
    else if (inSvc[0]) curLvl = LVL_L;
    else               curLvl = LVL_NONE;
  end

  assign irqReq        = winLvl > curLvl;
  assign strobe.grant  = cpuAck && irqReq && !cpuRet;
  assign strobe.retire = cpuRet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvc <= '0;
    end else if (strobe.retire) begin
      if (inSvc[2])      inSvc[2] <= 1'b0;
      else if (inSvc[1]) inSvc[1] <= 1'b0;
      else if (inSvc[0]) inSvc[0] <= 1'b0;
    end else if (strobe.grant) begin
      inSvc[winLvl - 2'd1] <= 1'b1;
    end
  end
endmodule

// File: rtl/intr_arb_top.sv
module intr_arb_top
  import intr_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_VEC-1:0] vecLvlHi,
  input  logic               cpuAck,
  input  logic               cpuRet,
  output logic               irqReq,
  output logic [ADDR_W-1:0]  irqVec
);
  ctl_strobe_t strobe;
  lvl_t        winLvl;
  logic [2:0]  inSvc;

  intr_arb_dp u_dp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn),
    .vecLvlHi(vecLvlHi), .strobe(strobe), .winLvl(winLvl), .irqVec(irqVec)
  );

  intr_arb_ctl u_ctl (
    .clk(clk), .rstN(rstN), .winLvl(winLvl), .cpuAck(cpuAck),
    .cpuRet(cpuRet), .irqReq(irqReq), .strobe(strobe), .inSvc(inSvc)
  );
endmodule

// File: rtl/intr_arb_chk.sv
module intr_arb_chk
  import intr_arb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cpuAck,
  input logic              cpuRet,
  input logic              irqReq,
  input logic [ADDR_W-1:0] irqVec,
  input ctl_strobe_t       strobe,
  input logic [2:0]        inSvc
);
  a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.grant |=> $stable(irqVec));

  a_r6_vec_form: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant |=> (irqVec[2:0] == 3'd3));

  a_r5_top_blocks: assert property (@(posedge clk) disable iff (!rstN)
    inSvc[2] |-> !irqReq);

  a_r7_ack_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && !irqReq && !cpuRet) |=> $stable(inSvc));

  a_r8_ret_empty: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRet && inSvc == 3'b000) |=> (inSvc == 3'b000));

  a_r8_ret_drops_one: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRet && inSvc != 3'b000) |=> ($countones(inSvc) == $countones($past(inSvc)) - 1));
endmodule

bind intr_arb_top intr_arb_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .cpuRet(cpuRet),
  .irqReq(irqReq), .irqVec(irqVec), .strobe(strobe), .inSvc(inSvc)
);

// File: tb/sim_intr_arb_top.sv
module sim_intr_arb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [20:0] srcReq;
  logic [20:0] srcEn;
  logic [9:0]  vecLvlHi;
  logic        cpuAck;
  logic        cpuRet;
  logic        irqReq;
  logic [15:0] irqVec;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;
  logic [15:0] expQ[$];
  logic [2:0]  mSvc;   // bench model of levels in service

  always #5 clk = ~clk;

  intr_arb_top u0 (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn),
    .vecLvlHi(vecLvlHi), .cpuAck(cpuAck), .cpuRet(cpuRet),
    .irqReq(irqReq), .irqVec(irqVec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int vecOf(input int s);
    if (s < 2)  return s;
    if (s < 5)  return 2;
    if (s < 7)  return 3;
    if (s < 8)  return 4;
    if (s < 10) return 5;
    if (s < 12) return 6;
    if (s < 15) return 7;
    if (s < 18) return 8;
    return 9;
  endfunction

  function automatic int curLevel();
    if (mSvc[2]) return 3;
    if (mSvc[1]) return 2;
    if (mSvc[0]) return 1;
    return 0;
  endfunction

  // R2, R3, R4, R5 reference
  task automatic model(output bit req, output int win, output int lvl);
    bit pend[10];
    for (int v = 0; v < 10; v++) pend[v] = 0;
    for (int s = 0; s < 21; s++) if (srcReq[s] && srcEn[s]) pend[vecOf(s)] = 1;
    lvl = 0; win = 0;
    for (int v = 0; v < 10; v++) begin
      int l;
      l = !pend[v] ? 0 : (vecLvlHi[v] ? (v < 2 ? 3 : 2) : 1);
      if (l > lvl) begin lvl = l; win = v; end
    end
    req = lvl > curLevel();
  endtask

  task automatic checkReq(input string tag);
    bit r; int w; int l;
    #1;
    model(r, w, l);
    chk(irqReq == r, tag, irqReq, r);
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic pulse(input bit ack, input bit ret, input string tag);
    bit r; int w; int l;
    logic [15:0] held;
    model(r, w, l);
    held = irqVec;
    cpuAck = ack; cpuRet = ret;
    if (ret) begin
      if (mSvc[2]) mSvc[2] = 0; else if (mSvc[1]) mSvc[1] = 0; else if (mSvc[0]) mSvc[0] = 0;
    end else if (ack && r) begin
      expQ.push_back(16'(3 + 8 * w));
      mSvc[l-1] = 1;
    end
    @(negedge clk);
    cpuAck = 0; cpuRet = 0;
    if (!(ack && r && !ret)) chk(irqVec == held, {tag, " R7 vector held"}, irqVec, held);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(irqVec == e, "R6 vector address", irqVec, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; srcReq = '0; srcEn = '0; vecLvlHi = '0; cpuAck = 0; cpuRet = 0; mSvc = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk(irqReq == 1'b0, "R1 reset irqReq", irqReq, 0);
    chk(irqVec == 16'h0, "R1 reset irqVec", irqVec, 0);
    @(negedge clk);

    // R2: disabled source has no effect
    srcReq[3] = 1;
    checkReq("R2 masked source");
    chk(irqReq == 0, "R2 masked source gives no request", irqReq, 0);
    srcEn[3] = 1;
    checkReq("R2 enabled source in vector 2");
    pulse(1, 0, "R6 grant L");          // expects 0x13
    checkReq("R5 same level blocked");
    chk(irqReq == 0, "R5 equal level refused", irqReq, 0);

    // R3: vector 5 raised to H preempts L
    srcReq[9] = 1; srcEn[9] = 1; vecLvlHi[5] = 1;
    checkReq("R3 H over L");
    pulse(1, 0, "R6 grant H");          // expects 0x2B

    // vector 1 at L does not preempt, at X it does
    srcReq[1] = 1; srcEn[1] = 1;
    checkReq("R5 lower blocked");
    vecLvlHi[1] = 1;
    checkReq("R3 X on vector 1");
    chk(irqReq == 1, "R3 X request", irqReq, 1);
    pulse(1, 0, "R6 grant X");          // expects 0x0B
    checkReq("R5 nothing above X");
    pulse(1, 0, "R7 ack without request");
    // R7: ack together with return is ignored, return applies
    pulse(1, 1, "R7 ack with return");
    checkReq("R8 X closed, X pending again");
    chk(irqReq == 1, "R8 X pending after return", irqReq, 1);
    srcReq = '0;
    pulse(0, 1, "R8 close H");
    pulse(0, 1, "R8 close L");
    pulse(0, 1, "R8 return on empty");

    // R4: tie at H between vectors 6 and 8 -> vector 6
    srcReq[16] = 1; srcEn[16] = 1; srcReq[11] = 1; srcEn[11] = 1;
    vecLvlHi = 10'b01_0100_0000;
    checkReq("R4 tie");
    pulse(1, 0, "R4 tie grant");        // expects 0x33
    pulse(0, 1, "R8 close tie");
    srcReq = '0; srcEn = '0; vecLvlHi = '0;
    checkReq("R2 idle");

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      int op;
      srcReq = 21'($urandom); srcEn = 21'($urandom); vecLvlHi = 10'($urandom);
      checkReq("R5 random request");
      op = $urandom_range(0, 5);
      if (op < 3)       pulse(1, 0, "R6 random ack");
      else if (op == 3) pulse(0, 1, "R8 random return");
      else if (op == 4) pulse(1, 1, "R7 random ack with return");
      else              @(negedge clk);
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule